// File: doc/BRIEF.md
# Vector Loop Step State Unit

This block holds the state that governs an element-by-element vector loop. The state is a vector length, a maximum vector length, a source element index, a destination element index and a vertical-first mode bit, all packed into one 64-bit state word. Two operations change it. A set-length operation loads a new length and may enter vertical-first mode. A step operation moves both element indices forward by one.

In vertical-first mode a program runs several instructions on element 0, then on element 1, and so on. Software closes each pass with an explicit step. When the step reaches the vector length, both indices return to zero and the mode is left. If the step asks for a record, a 4-bit condition field tells the program whether the loop has finished, and a conditional branch uses that answer to decide whether to loop again.

Each operation is presented for one cycle with `op_valid`. The state word is updated at the next clock edge. The result pulses (`gpr_we`, `cond_valid`) are high for exactly the one cycle that follows the operation.

Top module: `vls_state_unit`

## Requirements
- R1: A set-length operation (`op_code`=0) writes `len_imm` into both the vector length and the maximum vector length, replacing the old values, and zeroes both element indices.
- R2: One cycle after a set-length operation, `gpr_we` is high for one cycle and `gpr_data` holds the new length, zero-extended. `gpr_we` stays low after any other cycle.
- R3: A set-length operation copies `vf_req` into the vertical-first bit, which is bit 63 of the state word.
- R4: A step operation (`op_code`=1) whose incremented index is below the vector length adds one to the source index and one to the destination index, and leaves the vertical-first bit unchanged.
- R5: A step whose incremented index equals the vector length sets both indices to zero and clears the vertical-first bit.
- R6: A step with `rec_req`=1 that reaches the end raises `cond_valid` for one cycle, with `cond_field`=4'b0010. The field bits are LT=bit 3, GT=bit 2, EQ=bit 1, SO=bit 0, so this value is EQ=1 with all other bits 0.
- R7: A step with `rec_req`=1 that does not reach the end raises `cond_valid` with `cond_field`=4'b0100, which is GT=1 with all other bits 0.
- R8: A step with `rec_req`=0 updates the state but leaves `cond_valid` low. It also leaves `gpr_we` low.
- R9: A step issued while the vector length is zero leaves both indices at zero, clears the vertical-first bit, and reports EQ when a record is requested.
- R10: While `rst_n` is low, every state field and every output pulse is zero. A cycle without `op_valid` leaves the state word unchanged.
- R11: The state word layout is: maximum length in [6:0], length in [13:7], source index in [20:14], destination index in [27:21], vertical-first in [63]. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | An operation is presented in this cycle |
| op_code | input | 1 | 0 = set-length, 1 = step |
| len_imm | input | 7 | New length for set-length |
| vf_req | input | 1 | Enter vertical-first mode with set-length |
| rec_req | input | 1 | Step reports a condition field |
| state_word | output | 64 | Packed loop state |
| gpr_we | output | 1 | Register write strobe carrying the new length |
| gpr_data | output | 64 | New length, zero-extended |
| cond_valid | output | 1 | `cond_field` is meaningful |
| cond_field | output | 4 | LT, GT, EQ, SO from bit 3 down to bit 0 |

## Verification
The index wrap to zero, the exit from vertical-first mode and the EQ report all come from one step, and they must appear together at the same clock edge. The bench provokes this by stepping up to the length with lengths 3, 2, 0 and 127. In each case it samples the indices, bit 63 and the condition field in a single snapshot one cycle after the step. It also issues a set-length directly after a wrapping step, so the reload and the wrap land in back-to-back cycles. It then checks that no pulse from one operation is left over in the other's result cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    OP_SETLEN = 1'b0,
    OP_STEP   = 1'b1
  } vls_op_e;

  localparam int STATE_W = 64;
  localparam int VF_BIT  = 63;
  localparam int CF_W    = 4;
  localparam int CF_LT   = 3;
  localparam int CF_GT   = 2;
  localparam int CF_EQ   = 1;
  localparam int CF_SO   = 0;
  localparam int NLANE   = 2;
endpackage

// File: rtl/vls_rst_sync.sv
module vls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/vls_idx_step.sv
module vls_idx_step #(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] vec_len,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             at_end
);
  logic [IDX_W:0] inc;

  always_comb begin
    inc     = {1'b0, cur_idx} + {{IDX_W{1'b0}}, 1'b1};
    at_end  = (vec_len == '0) || (inc >= {1'b0, vec_len});
    nxt_idx = at_end ? '0 : inc[IDX_W-1:0];
  end
endmodule

// File: rtl/vls_cond_gen.sv
module vls_cond_gen
  import vls_pkg::*;
(
  input  logic            reached_end,
  output logic [CF_W-1:0] field
);
  always_comb begin
    field        = '0;
    field[CF_EQ] = reached_end;
    field[CF_GT] = ~reached_end;
  end
endmodule

// File: rtl/vls_state_unit.sv
module vls_state_unit
  import vls_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int GPR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic               op_code,
  input  logic [IDX_W-1:0]   len_imm,
  input  logic               vf_req,
  input  logic               rec_req,
  output logic [STATE_W-1:0] state_word,
  output logic               gpr_we,
  output logic [GPR_W-1:0]   gpr_data,
  output logic               cond_valid,
  output logic [CF_W-1:0]    cond_field
);
  localparam int MVL_LSB = 0;
  localparam int VL_LSB  = IDX_W;
  localparam int SRC_LSB = 2 * IDX_W;
  localparam int DST_LSB = 3 * IDX_W;

  logic rst_n_int;

  logic [IDX_W-1:0] vl_q, vl_d, mvl_q, mvl_d;
  logic [IDX_W-1:0] idx_q [NLANE];
  logic [IDX_W-1:0] idx_d [NLANE];
  logic [IDX_W-1:0] idx_nxt [NLANE];
  logic [NLANE-1:0] lane_end;
  logic             vf_q, vf_d;
  logic             gpr_we_q, gpr_we_d;
  logic [GPR_W-1:0] gpr_data_q, gpr_data_d;
  logic             cv_q, cv_d;
  logic [CF_W-1:0]  cf_q, cf_d, cf_calc;
  logic             state_en;

  vls_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // lane 0 walks the source index, lane 1 the destination index
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    vls_idx_step #(.IDX_W(IDX_W)) u_step (
      .cur_idx (idx_q[g]),
      .vec_len (vl_q),
      .nxt_idx (idx_nxt[g]),
      .at_end  (lane_end[g])
    );
  end

  vls_cond_gen u_cond (
    .reached_end (lane_end[0]),
    .field       (cf_calc)
  );

  assign state_en = op_valid;

  always_comb begin
    vl_d       = vl_q;
    mvl_d      = mvl_q;
    vf_d       = vf_q;
    idx_d      = idx_q;
    gpr_we_d   = 1'b0;
    gpr_data_d = gpr_data_q;
    cv_d       = 1'b0;
    cf_d       = '0;
    if (op_valid) begin
      if (vls_op_e'(op_code) == OP_SETLEN) begin
        vl_d       = len_imm;
        mvl_d      = len_imm;
        vf_d       = vf_req;
        for (int i = 0; i < NLANE; i++) idx_d[i] = '0;
        gpr_we_d   = 1'b1;
        gpr_data_d = GPR_W'(len_imm);
      end else begin
        for (int i = 0; i < NLANE; i++) idx_d[i] = idx_nxt[i];
        if (lane_end[0]) vf_d = 1'b0;
        cv_d = rec_req;
        cf_d = rec_req ? cf_calc : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vl_q  <= '0;
      mvl_q <= '0;
      vf_q  <= 1'b0;
      for (int i = 0; i < NLANE; i++) idx_q[i] <= '0;
    end else if (state_en) begin
      vl_q  <= vl_d;
      mvl_q <= mvl_d;
      vf_q  <= vf_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      gpr_we_q   <= 1'b0;
      gpr_data_q <= '0;
      cv_q       <= 1'b0;
      cf_q       <= '0;
    end else begin
      gpr_we_q   <= gpr_we_d;
      gpr_data_q <= gpr_data_d;
      cv_q       <= cv_d;
      cf_q       <= cf_d;
    end
  end

  always_comb begin
    state_word                          = '0;
    state_word[MVL_LSB +: IDX_W]        = mvl_q;
    state_word[VL_LSB  +: IDX_W]        = vl_q;
    state_word[SRC_LSB +: IDX_W]        = idx_q[0];
    state_word[DST_LSB +: IDX_W]        = idx_q[1];
    state_word[VF_BIT]                  = vf_q;
  end

  assign gpr_we     = gpr_we_q;
  assign gpr_data   = gpr_data_q;
  assign cond_valid = cv_q;
  assign cond_field = cf_q;
endmodule

// File: rtl/vls_state_unit_chk.sv
module vls_state_unit_chk
  import vls_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int GPR_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               op_code,
  input logic [IDX_W-1:0]   len_imm,
  input logic               vf_req,
  input logic               rec_req,
  input logic [STATE_W-1:0] state_word,
  input logic               gpr_we,
  input logic [GPR_W-1:0]   gpr_data,
  input logic               cond_valid,
  input logic [CF_W-1:0]    cond_field
);
  logic [IDX_W-1:0] c_mvl, c_vl, c_src, c_dst;
  logic [IDX_W:0]   c_inc;
  logic             is_set, is_step;

  assign c_mvl   = state_word[0 +: IDX_W];
  assign c_vl    = state_word[IDX_W +: IDX_W];
  assign c_src   = state_word[2*IDX_W +: IDX_W];
  assign c_dst   = state_word[3*IDX_W +: IDX_W];
  assign c_inc   = {1'b0, c_src} + {{IDX_W{1'b0}}, 1'b1};
  assign is_set  = op_valid && (op_code == OP_SETLEN);
  assign is_step = op_valid && (op_code == OP_STEP);

  assert_setlen_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> (c_vl == $past(len_imm)) && (c_mvl == $past(len_imm)) &&
               (c_src == '0) && (c_dst == '0));

  assert_gpr_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> gpr_we && (gpr_data == GPR_W'($past(len_imm))));

  assert_vf_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> state_word[VF_BIT] == $past(vf_req));

  assert_step_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_step && (c_vl != '0) && (c_inc < {1'b0, c_vl})) |=>
      (c_src == $past(c_src) + 1'b1) && (c_dst == $past(c_dst) + 1'b1) &&
      (state_word[VF_BIT] == $past(state_word[VF_BIT])));

  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_step && ((c_vl == '0) || (c_inc >= {1'b0, c_vl}))) |=>
      (c_src == '0) && (c_dst == '0) && !state_word[VF_BIT]);

  assert_cond_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> ($countones(cond_field) == 1) && !cond_field[CF_LT] &&
                   !cond_field[CF_SO]);

  assert_step_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_step && !rec_req) |=> !cond_valid && !gpr_we);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(state_word));

  assert_step_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_step && rec_req && vf_req == vf_req) |=> cond_valid);
endmodule

bind vls_state_unit vls_state_unit_chk #(.IDX_W(IDX_W), .GPR_W(GPR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .len_imm    (len_imm),
  .vf_req     (vf_req),
  .rec_req    (rec_req),
  .state_word (state_word),
  .gpr_we     (gpr_we),
  .gpr_data   (gpr_data),
  .cond_valid (cond_valid),
  .cond_field (cond_field)
);

// File: tb/tb_vls_state_unit.sv
module tb_vls_state_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 7;
  localparam int GPR_W      = 64;
  localparam int WDOG_LIMIT = 20000;

  typedef struct packed {
    logic             op;
    logic [IDX_W-1:0] len;
    logic             vf;
    logic             rec;
    logic [IDX_W-1:0] e_vl;
    logic [IDX_W-1:0] e_idx;
    logic             e_vf;
    logic             e_gwe;
    logic             e_cv;
    logic [3:0]       e_cf;
  } vec_t;

  localparam int NV = 13;
  // op 0 = set-length, 1 = step; cond 4'b0100 = GT, 4'b0010 = EQ
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd3,   1'b1, 1'b0, 7'd3,   7'd0, 1'b1, 1'b1, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd3,   7'd1, 1'b1, 1'b0, 1'b1, 4'b0100},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd3,   7'd2, 1'b1, 1'b0, 1'b1, 4'b0100},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd3,   7'd0, 1'b0, 1'b0, 1'b1, 4'b0010},
    '{1'b0, 7'd2,   1'b1, 1'b0, 7'd2,   7'd0, 1'b1, 1'b1, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b0, 7'd2,   7'd1, 1'b1, 1'b0, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd2,   7'd0, 1'b0, 1'b0, 1'b1, 4'b0010},
    '{1'b0, 7'd10,  1'b0, 1'b0, 7'd10,  7'd0, 1'b0, 1'b1, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b0, 7'd10,  7'd1, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{1'b0, 7'd0,   1'b1, 1'b0, 7'd0,   7'd0, 1'b1, 1'b1, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd0,   7'd0, 1'b0, 1'b0, 1'b1, 4'b0010},
    '{1'b0, 7'd127, 1'b1, 1'b0, 7'd127, 7'd0, 1'b1, 1'b1, 1'b0, 4'b0000},
    '{1'b1, 7'd0,   1'b0, 1'b1, 7'd127, 7'd1, 1'b1, 1'b0, 1'b1, 4'b0100}
  };

  logic             clk;
  logic             rst_n;
  logic             op_valid;
  logic             op_code;
  logic [IDX_W-1:0] len_imm;
  logic             vf_req;
  logic             rec_req;
  logic [63:0]      state_word;
  logic             gpr_we;
  logic [GPR_W-1:0] gpr_data;
  logic             cond_valid;
  logic [3:0]       cond_field;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  vls_state_unit #(.IDX_W(IDX_W), .GPR_W(GPR_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .len_imm    (len_imm),
    .vf_req     (vf_req),
    .rec_req    (rec_req),
    .state_word (state_word),
    .gpr_we     (gpr_we),
    .gpr_data   (gpr_data),
    .cond_valid (cond_valid),
    .cond_field (cond_field)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_word(input logic [6:0] vl, input logic [6:0] idx,
                                          input logic vf);
    logic [63:0] w;
    w        = '0;
    w[6:0]   = vl;
    w[13:7]  = vl;
    w[20:14] = idx;
    w[27:21] = idx;
    w[63]    = vf;
    return w;
  endfunction

  task automatic issue(input logic op, input logic [6:0] len, input logic vf,
                       input logic rec);
    op_valid = 1'b1;
    op_code  = op;
    len_imm  = len;
    vf_req   = vf;
    rec_req  = rec;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; done = 1'b0;
    op_valid = 1'b0; op_code = 1'b0; len_imm = '0; vf_req = 1'b0; rec_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(state_word == 64'd0, "R10 reset word", state_word, 64'd0);
    chk(!gpr_we && !cond_valid, "R10 reset pulses", {gpr_we, cond_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1..R9, R11
    for (int k = 0; k < NV; k++) begin
      logic [63:0] ew;
      issue(VECS[k].op, VECS[k].len, VECS[k].vf, VECS[k].rec);
      ew = mk_word(VECS[k].e_vl, VECS[k].e_idx, VECS[k].e_vf);
      chk(state_word == ew, "R1/R3/R4/R5/R9/R11 state word", state_word, ew);
      chk(gpr_we == VECS[k].e_gwe, "R2/R8 gpr_we", gpr_we, VECS[k].e_gwe);
      if (VECS[k].e_gwe)
        chk(gpr_data == 64'(VECS[k].e_vl), "R2 gpr_data", gpr_data, 64'(VECS[k].e_vl));
      chk(cond_valid == VECS[k].e_cv, "R6/R7/R8 cond_valid", cond_valid, VECS[k].e_cv);
      if (VECS[k].e_cv)
        chk(cond_field == VECS[k].e_cf, "R6/R7 cond_field", cond_field, VECS[k].e_cf);
    end

    // R10 idle cycle: state held, pulses gone
    begin
      logic [63:0] held;
      held = state_word;
      @(negedge clk);
      chk(state_word == held, "R10 idle hold", state_word, held);
      chk(!gpr_we && !cond_valid, "R10 idle pulses", {gpr_we, cond_valid}, 0);
    end

    // R4/R5 boundary: length 127 stepped to the last index, then wrap
    for (int s = 2; s <= 126; s++) issue(1'b1, 7'd0, 1'b0, 1'b0);
    chk(state_word == mk_word(7'd127, 7'd126, 1'b1), "R4 idx 126",
        state_word, mk_word(7'd127, 7'd126, 1'b1));
    issue(1'b1, 7'd0, 1'b0, 1'b1);
    chk(state_word == mk_word(7'd127, 7'd0, 1'b0), "R5 wrap at 127",
        state_word, mk_word(7'd127, 7'd0, 1'b0));
    chk(cond_valid && cond_field == 4'b0010, "R6 EQ at 127", {cond_valid, cond_field}, 5'b10010);
    // set-length right after the wrap: no stale cond pulse
    issue(1'b0, 7'd5, 1'b1, 1'b1);
    chk(!cond_valid, "R8 no cond on set-length", cond_valid, 0);
    chk(state_word == mk_word(7'd5, 7'd0, 1'b1), "R1 reload after wrap",
        state_word, mk_word(7'd5, 7'd0, 1'b1));

    // R10 reset in the middle of a loop
    issue(1'b1, 7'd0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(state_word == 64'd0, "R10 async reset", state_word, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_word == 64'd0, "R10 after release", state_word, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule